// File: doc/BRIEF.md
# Upscaling VGA Scan-Out Generator

This block produces the raster timing for an 800x600, 60 Hz VGA display and fills that raster from a small on-chip frame store of 200x150 pixels. Each stored pixel is 12 bits wide and is drawn as a 4x4 block of display pixels, so the whole store covers the screen. The block runs in the system clock domain. It advances one display pixel on each cycle where the pixel-clock enable is high; at the nominal setting this is one cycle in three of a 120 MHz clock, which gives 40 MHz.

A host fills the frame store through a synchronous write port that takes a row, a column and a 12-bit word. Writes may happen at any time and do not wait for blanking, so a frame can show a mix of old and new contents. The colour outputs are three 4-bit buses, and both syncs are active high. All outputs come from registers, and control is delayed to match the store's read latency, so colour and sync stay aligned at the pins.

Top module: `vga_upscale_scanout`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP enabled cycles (800+40+128+88 = 1056 by default). hsync_o is 1 exactly for pixel positions H_ACTIVE+H_FP up to H_ACTIVE+H_FP+H_SYNC-1 and is 0 at every other position.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (600+1+4+23 = 628 by default). vsync_o is 1 for every pixel of lines V_ACTIVE+V_FP up to V_ACTIVE+V_FP+V_SYNC-1 (lines 601 to 604 by default), active, porch and hsync pixels included.
- R3: red_o, green_o and blue_o are 0 for every pixel whose column is H_ACTIVE or more, and for every pixel of a line whose number is V_ACTIVE or more.
- R4: An active pixel (x, y) shows the stored word at row y>>2 and column x>>2. Stored bits [3:0] drive red_o, bits [7:4] drive green_o and bits [11:8] drive blue_o.
- R5: The colour, the syncs and frame_start_o for a counter position appear together two enabled cycles after the cycle in which the counters hold that position.
- R6: While pix_en_i is 0, the counters and all colour and sync outputs hold their values.
- R7: After reset, all colour and sync outputs and frame_start_o are 0. The first pixel the block displays is pixel 0 of line 0.
- R8: frame_start_o is 1 for exactly one clock cycle per frame: the cycle in which the outputs first show pixel 0 of line 0.
- R9: A write with wr_en_i high stores wr_data_i at (wr_row_i, wr_col_i), and all later reads see the new value. A read of the same cell in the same cycle returns the old value.
- R10: A write whose row is FB_ROWS or more, or whose column is FB_COLS or more, changes no stored pixel. This includes the cell that row*FB_COLS+col would alias to.
- R11: Writes take effect whether pix_en_i is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; one display pixel per high cycle |
| wr_en_i | input | 1 | Frame store write strobe |
| wr_row_i | input | clog2(V_ACTIVE/4+1) (8) | Frame store row index |
| wr_col_i | input | clog2(H_ACTIVE/4+1) (8) | Frame store column index |
| wr_data_i | input | 12 | Pixel word: blue [11:8], green [7:4], red [3:0] |
| red_o | output | 4 | Red level |
| green_o | output | 4 | Green level |
| blue_o | output | 4 | Blue level |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| frame_start_o | output | 1 | One-cycle pulse when pixel 0 of line 0 is shown |

## Verification
A wrong horizontal or vertical count appears at the ports within one line or one frame. It shows as a sync edge at the wrong pixel, or as frame_start_o pulsing at the wrong spacing. An address fault, such as a wrong replication shift or a wrong row stride, shows as a colour mismatch on the first active line that reads the affected cell. A control pipeline that has a different depth from the read path shifts colour against sync by one pixel, and this shows on the first active edge of every line. A write port that lets through out-of-range indices corrupts an aliased cell. That corruption becomes visible at the next scan of that cell, at most one frame later.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  parameter int CH_W = 4;

  typedef struct packed {
    logic [CH_W-1:0] blu;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] red;
  } pix_t;

  typedef struct packed {
    logic frame_head;
    logic vsync;
    logic hsync;
    logic active;
  } scan_ctl_t;
endpackage

// File: rtl/vga_raster_timer.sv
module vga_raster_timer
  import vga_scan_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BP     = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HC_W    = $clog2(H_TOTAL + 1),
  localparam int VC_W    = $clog2(V_TOTAL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_en_i,
  output logic [HC_W-1:0] h_o,
  output logic [VC_W-1:0] v_o,
  output scan_ctl_t       ctl_o
);
  localparam logic [HC_W-1:0] H_LAST   = HC_W'(H_TOTAL - 1);
  localparam logic [VC_W-1:0] V_LAST   = VC_W'(V_TOTAL - 1);
  localparam logic [HC_W-1:0] H_ACT    = HC_W'(H_ACTIVE);
  localparam logic [VC_W-1:0] V_ACT    = VC_W'(V_ACTIVE);
  localparam logic [HC_W-1:0] HS_BEG   = HC_W'(H_ACTIVE + H_FP);
  localparam logic [HC_W-1:0] HS_END   = HC_W'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VC_W-1:0] VS_BEG   = VC_W'(V_ACTIVE + V_FP);
  localparam logic [VC_W-1:0] VS_END   = VC_W'(V_ACTIVE + V_FP + V_SYNC);

  logic [HC_W-1:0] h_q;
  logic [VC_W-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (pix_en_i) begin
      if (h_q == H_LAST) begin
        h_q <= '0;
        v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  always_comb begin
    ctl_o.active     = (h_q < H_ACT) && (v_q < V_ACT);
    ctl_o.hsync      = (h_q >= HS_BEG) && (h_q < HS_END);
    ctl_o.vsync      = (v_q >= VS_BEG) && (v_q < VS_END);
    ctl_o.frame_head = (h_q == '0) && (v_q == '0);
  end

  assign h_o = h_q;
  assign v_o = v_q;
endmodule

// File: rtl/vga_fb_ram.sv
module vga_fb_ram #(
  parameter int DEPTH  = 30000,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem [DEPTH];

  // nonblocking read and write: same-address collision returns old word
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/vga_align_pipe.sv
module vga_align_pipe #(
  parameter int          W      = 4,
  parameter int          STAGES = 1,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg <= {STAGES{RST}};
      end else if (en_i) begin
        stg[0] <= d_i;
        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
    end
    assign q_o = stg[STAGES-1];
  end
endmodule

// File: rtl/vga_upscale_scanout.sv
module vga_upscale_scanout
  import vga_scan_pkg::*;
#(
  parameter int H_ACTIVE   = 800,
  parameter int H_FP       = 40,
  parameter int H_SYNC     = 128,
  parameter int H_BP       = 88,
  parameter int V_ACTIVE   = 600,
  parameter int V_FP       = 1,
  parameter int V_SYNC     = 4,
  parameter int V_BP       = 23,
  parameter int SCALE_LOG2 = 2
) (
  input  logic                                                 clk_i,
  input  logic                                                 rst_ni,
  input  logic                                                 pix_en_i,
  input  logic                                                 wr_en_i,
  input  logic [$clog2((V_ACTIVE >> SCALE_LOG2) + 1)-1:0]      wr_row_i,
  input  logic [$clog2((H_ACTIVE >> SCALE_LOG2) + 1)-1:0]      wr_col_i,
  input  logic [3*vga_scan_pkg::CH_W-1:0]                      wr_data_i,
  output logic [vga_scan_pkg::CH_W-1:0]                        red_o,
  output logic [vga_scan_pkg::CH_W-1:0]                        green_o,
  output logic [vga_scan_pkg::CH_W-1:0]                        blue_o,
  output logic                                                 hsync_o,
  output logic                                                 vsync_o,
  output logic                                                 frame_start_o
);
  localparam int FB_COLS = H_ACTIVE >> SCALE_LOG2;
  localparam int FB_ROWS = V_ACTIVE >> SCALE_LOG2;
  localparam int DEPTH   = FB_COLS * FB_ROWS;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int COL_W   = $clog2(FB_COLS + 1);
  localparam int ROW_W   = $clog2(FB_ROWS + 1);
  localparam int DATA_W  = 3 * CH_W;
  localparam int RD_LAT  = 1;
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HC_W    = $clog2(H_TOTAL + 1);
  localparam int VC_W    = $clog2(V_TOTAL + 1);
  localparam logic [ADDR_W-1:0] COLS_A = ADDR_W'(FB_COLS);
  localparam logic [COL_W-1:0]  COLS_C = COL_W'(FB_COLS);
  localparam logic [ROW_W-1:0]  ROWS_R = ROW_W'(FB_ROWS);

  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt;
  scan_ctl_t       ctl, ctl_d;

  vga_raster_timer #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_en_i(pix_en_i),
    .h_o     (h_cnt),
    .v_o     (v_cnt),
    .ctl_o   (ctl)
  );

  // replication: drop the low SCALE_LOG2 bits of each counter
  logic [COL_W-1:0]  rd_col;
  logic [ROW_W-1:0]  rd_row;
  logic [ADDR_W-1:0] rd_addr;
  assign rd_col  = COL_W'(h_cnt >> SCALE_LOG2);
  assign rd_row  = ROW_W'(v_cnt >> SCALE_LOG2);
  assign rd_addr = ctl.active ? (ADDR_W'(rd_row) * COLS_A + ADDR_W'(rd_col)) : '0;

  logic              wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  assign wr_ok   = wr_en_i && (wr_row_i < ROWS_R) && (wr_col_i < COLS_C);
  assign wr_addr = ADDR_W'(wr_row_i) * COLS_A + ADDR_W'(wr_col_i);

  logic [DATA_W-1:0] rd_data;

  vga_fb_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fb (
    .clk_i    (clk_i),
    .rd_en_i  (pix_en_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .wr_en_i  (wr_ok),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data_i)
  );

  vga_align_pipe #(.W($bits(scan_ctl_t)), .STAGES(RD_LAT)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pix_en_i),
    .d_i   (ctl),
    .q_o   (ctl_d)
  );

  pix_t px;
  assign px = pix_t'(rd_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_o         <= '0;
      green_o       <= '0;
      blue_o        <= '0;
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= pix_en_i && ctl_d.frame_head;
      if (pix_en_i) begin
        red_o   <= ctl_d.active ? px.red : '0;
        green_o <= ctl_d.active ? px.grn : '0;
        blue_o  <= ctl_d.active ? px.blu : '0;
        hsync_o <= ctl_d.hsync;
        vsync_o <= ctl_d.vsync;
      end
    end
  end
endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk #(
  parameter int H_SYNC = 128,
  parameter int CH_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pix_en_i,
  input logic [CH_W-1:0] red_o,
  input logic [CH_W-1:0] green_o,
  input logic [CH_W-1:0] blue_o,
  input logic            hsync_o,
  input logic            vsync_o,
  input logic            frame_start_o
);
  logic [15:0] hs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hs_run <= '0;
    else if (!hsync_o)  hs_run <= '0;
    else if (pix_en_i)  hs_run <= hs_run + 1'b1;
  end

  // R1
  hs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_run <= 16'(H_SYNC));

  // R3
  hs_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> ({red_o, green_o, blue_o} == '0));

  // R3
  vs_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> ({red_o, green_o, blue_o} == '0));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable({red_o, green_o, blue_o, hsync_o, vsync_o}));

  // R8
  fs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  // R8
  fs_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (!hsync_o && !vsync_o));
endmodule

bind vga_upscale_scanout vga_scan_chk #(.H_SYNC(H_SYNC), .CH_W(vga_scan_pkg::CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_en_i     (pix_en_i),
  .red_o        (red_o),
  .green_o      (green_o),
  .blue_o       (blue_o),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .frame_start_o(frame_start_o)
);

// File: tb/vga_upscale_scanout_test.sv
`timescale 1ns/1ps
module vga_upscale_scanout_test;
  localparam int HA = 20, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int COLS = HA / 4;
  localparam int ROWS = VA / 4;
  localparam int COL_W = $clog2(COLS + 1);
  localparam int ROW_W = $clog2(ROWS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic wr_en = 1'b0;
  logic [ROW_W-1:0] wr_row = '0;
  logic [COL_W-1:0] wr_col = '0;
  logic [11:0] wr_data = '0;
  logic [3:0] red_o, green_o, blue_o;
  logic hsync_o, vsync_o, frame_start_o;

  always #2.5 clk = ~clk;

  vga_upscale_scanout #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .SCALE_LOG2(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en),
    .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col), .wr_data_i(wr_data),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .frame_start_o(frame_start_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string rgb_tag = "R4";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference: entry = {active, frame_head, vsync, hsync, rgb}
  logic [11:0] ref_fb [COLS*ROWS];
  int mx, my;
  logic [17:0] pq [$];
  logic [17:0] exp_o;
  logic exp_fs;
  int fs_exp_cnt = 0, fs_seen_cnt = 0;

  initial for (int i = 0; i < COLS*ROWS; i++) ref_fb[i] = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx = 0; my = 0;
      pq = {18'h0};
      exp_o = '0;
      exp_fs = 1'b0;
    end else begin
      exp_fs = 1'b0;
      if (pix_en) begin
        logic [17:0] cur;
        logic act;
        act = (mx < HA) && (my < VA);
        cur[17] = act;
        cur[16] = (mx == 0) && (my == 0);
        cur[15] = (my >= VA + VF) && (my < VA + VF + VS);
        cur[14] = (mx >= HA + HF) && (mx < HA + HF + HS);
        cur[13:12] = 2'b00;
        cur[11:0] = act ? ref_fb[(my / 4) * COLS + (mx / 4)] : 12'h0;
        pq.push_back(cur);
        exp_o = pq.pop_front();
        exp_fs = exp_o[16];
        if (exp_fs) fs_exp_cnt++;
        mx++;
        if (mx == HT) begin
          mx = 0;
          my = (my == VT - 1) ? 0 : my + 1;
        end
      end
      if (wr_en && (int'(wr_row) < ROWS) && (int'(wr_col) < COLS))
        ref_fb[int'(wr_row) * COLS + int'(wr_col)] = wr_data;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(exp_o[17] ? rgb_tag : "R3", {blue_o, green_o, red_o}, exp_o[11:0]);
      chk("R1", hsync_o, exp_o[14]);
      chk("R2", vsync_o, exp_o[15]);
      chk("R8", frame_start_o, exp_fs);
      if (frame_start_o) fs_seen_cnt++;
    end
  end

  task automatic step(input logic en, input logic we, input int r, input int c, input logic [11:0] d);
    pix_en  = en;
    wr_en   = we;
    wr_row  = ROW_W'(r);
    wr_col  = COL_W'(c);
    wr_data = d;
    @(negedge clk);
  endtask

  function automatic logic [11:0] pat(input int r, input int c);
    return 12'(12'h137 * (r + 1) + 12'h05A * c);
  endfunction

  task automatic wait_fs();
    int n = 0;
    while (frame_start_o !== 1'b1 && n < 4 * HT * VT) begin
      step(1, 0, 0, 0, 0);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [16:0] snap;
    logic [11:0] saved;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7", {frame_start_o, vsync_o, hsync_o, blue_o, green_o, red_o}, 0);

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        step(0, 1, r, c, pat(r, c));

    // R5: first enable only loads the read stage
    step(1, 0, 0, 0, 0);
    chk("R5", {frame_start_o, blue_o, green_o, red_o}, 0);
    // R7: second enable shows pixel 0 of line 0
    step(1, 0, 0, 0, 0);
    chk("R7", {frame_start_o, blue_o, green_o, red_o}, {1'b1, pat(0, 0)});

    repeat (HT * VT) step(1, 0, 0, 0, 0);

    // R11: writes during disabled cycles
    rgb_tag = "R11";
    for (int i = 0; i < 3 * HT * VT; i++) begin
      if (i % 3 == 0) step(1, 0, 0, 0, 0);
      else step(0, 1, $urandom_range(ROWS - 1), $urandom_range(COLS - 1), 12'($urandom));
    end

    // R6: stall with writes, outputs hold
    rgb_tag = "R6";
    repeat (7) step(1, 0, 0, 0, 0);
    snap = {frame_start_o, vsync_o, hsync_o, blue_o, green_o, red_o};
    repeat (10) step(0, 1, $urandom_range(ROWS - 1), $urandom_range(COLS - 1), 12'($urandom));
    chk("R6", {1'b0, vsync_o, hsync_o, blue_o, green_o, red_o}, {1'b0, snap[15:0]});

    // R9: writes during continuous scan
    rgb_tag = "R9";
    repeat (HT * VT) step(1, 1, $urandom_range(ROWS - 1), $urandom_range(COLS - 1), 12'($urandom));
    step(1, 1, 0, 0, 12'hA5C);
    wait_fs();
    chk("R9", {blue_o, green_o, red_o}, 12'hA5C);

    // R10: out-of-range writes, including aliases of row 1
    rgb_tag = "R10";
    saved = ref_fb[COLS];
    for (int i = 0; i < HT * VT; i++) begin
      if (i % 2 == 0) step(1, 1, ROWS, i % COLS, 12'hFFF);
      else step(1, 1, 0, COLS + (i % 3), 12'hEEE);
    end
    wait_fs();
    repeat (4 * HT) step(1, 0, 0, 0, 0);
    chk("R10", {blue_o, green_o, red_o}, saved);

    // R8: one pulse per frame
    step(1, 0, 0, 0, 0);
    chk("R8", fs_seen_cnt, fs_exp_cnt);
    finish_run();
  end
endmodule